// File: doc/BRIEF.md
# Synchronous Multi-Channel PWM Bank

This block drives a group of PWM outputs from one shared period counter, so every channel's edges line up in time. Software stages a period value and one duty value per channel in shadow registers. The staged values move into the live compare registers together, and only at a period boundary. This guarantees that a group of related outputs never shows a mixed old/new setting within one period. A single run enable starts the shared counter, and with it every channel that is marked synchronous. Channels that are not marked stay low.

There are two commit policies. In the first, software raises an unlock strobe, and the staged set is committed at the next boundary. In the second, automatic mode, the staged set is committed at every boundary. The counter runs in one of two shapes. Left-aligned counting ramps up and wraps, so one period is P cycles. Centre-aligned counting ramps up and then down, so one period is 2·P cycles and the output frequency is half that of left-aligned mode for the same setting. Phase-shifted waveforms can be built outside the block by combining two aligned channels, for example with an XOR.

Top module: `sync_pwm_bank`

## Requirements
- R1: All channels compare against one shared counter, and asserting `run_en` alone starts every channel whose `sync_mask` bit is 1. Two such channels with equal live duty therefore produce identical outputs on every cycle.
- R2: While `run_en` is 0:
  - the counter is held at 0 and `pwm_out` is all zero one cycle later;
  - the live period and duty registers follow the shadow registers;
  - any pending unlock is dropped.
  - After reset, `pwm_out` is 0.
- R3: With `centre_en`=0, the counter counts 0..P-1 and then wraps to 0, where P is the live period. A channel output is high, one cycle after the counter value, whenever the counter is below the channel's live duty. A duty of d with 0≤d≤P therefore gives d high cycles per P cycles.
- R4: With `centre_en`=1, the counter counts up 0..P-1, holds P-1 for one cycle while turning, counts down to 0, and holds 0 for one cycle. One period is therefore 2·P cycles, and a duty of P/2 gives 50 % high time.
- R5: A write to a duty or period shadow register (`duty_wr`/`period_wr`) has no effect on the outputs until a commit happens.
- R6: After an `unlock` strobe, all staged values (every duty and the period) load into the live registers together at the end of the current period. In left-aligned mode that is the wrap; in centre-aligned mode it is the bottom turn.
- R7: The pending unlock clears itself when the commit happens. Several strobes before one boundary cause a single commit, and later shadow writes wait for a new strobe.
- R8: With `auto_load`=1, the staged values commit at every period boundary without any strobe.
- R9: A live duty of 0 keeps the channel low for the whole period.
- R10: A live duty greater than or equal to the live period keeps the channel high for the whole period.
- R11: The period is shadowed and commits at the same boundary as the duties, so the counter length never changes inside a period. A staged period of 0 is treated as 1.
- R12: A channel whose `sync_mask` bit is 0 drives its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Global enable for the shared counter |
| centre_en | input | 1 | 1 = centre-aligned up/down counting, 0 = left-aligned; change only while stopped |
| auto_load | input | 1 | 1 = commit staged values at every period boundary |
| sync_mask | input | NCH | Per-channel synchronous-channel enable |
| period_wr | input | 1 | Write strobe for the period shadow |
| period_data | input | CW | Period value to stage |
| duty_wr | input | 1 | Write strobe for a duty shadow |
| duty_sel | input | CHW | Channel index for the duty write |
| duty_data | input | CW | Duty value to stage |
| unlock | input | 1 | One-cycle strobe requesting a commit at the next boundary |
| pwm_out | output | NCH | Pulse outputs, one per channel |

## Verification
The bench goes after the commit timing in several ways:
- It stages duties and a new period with no unlock. A design that loaded shadows directly would show the new high count at once.
- It double-strobes unlock and then writes again. A design whose pending flag does not clear would keep loading later writes.
- It checks the duty extremes 0 and ≥P. An off-by-one compare would leak a single-cycle pulse, or drop one.
- It runs centre-aligned mode. A turn that does not hold the end values would make the high count uneven, or make the period 2·P−2.

A behavioural model is compared on every cycle, so a commit one cycle early or late shows up as a cycle mismatch even when the per-period counts agree.

// File: rtl/spb_pkg.sv
package spb_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } ramp_dir_t;
endpackage

// File: rtl/spb_timebase.sv
module spb_timebase
   import spb_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic          centre_en,
   input  logic [CW-1:0] period_act,
   output logic [CW-1:0] cnt,
   output logic          at_end
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   ramp_dir_t     dir_q;
   logic          at_top;

   assign at_top = (cnt_q >= period_act - ONE);
   assign cnt    = cnt_q;

   always_comb begin
      if (centre_en) at_end = run_en && (dir_q == DIR_DOWN) && (cnt_q == '0);
      else           at_end = run_en && at_top;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run_en) begin
         cnt_q <= '0;
         dir_q <= DIR_UP;
      end else if (centre_en) begin
         if (dir_q == DIR_UP) begin
            if (at_top) dir_q <= DIR_DOWN;
            else        cnt_q <= cnt_q + ONE;
         end else begin
            if (cnt_q == '0) dir_q <= DIR_UP;
            else             cnt_q <= cnt_q - ONE;
         end
      end else begin
         dir_q <= DIR_UP;
         cnt_q <= at_top ? '0 : cnt_q + ONE;
      end
   end

   a_r3_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> (cnt_q < period_act));
   a_r2_cnt_held_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cnt_q == '0));
endmodule

// File: rtl/spb_staging.sv
module spb_staging #(
   parameter int NCH = 4,
   parameter int CW  = 16,
   parameter int CHW = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_en,
   input  logic                    at_end,
   input  logic                    auto_load,
   input  logic                    unlock,
   input  logic                    period_wr,
   input  logic [CW-1:0]           period_data,
   input  logic                    duty_wr,
   input  logic [CHW-1:0]          duty_sel,
   input  logic [CW-1:0]           duty_data,
   output logic [CW-1:0]           period_act,
   output logic [NCH-1:0][CW-1:0]  duty_act,
   output logic                    commit
);
   logic [NCH-1:0][CW-1:0] duty_shd;
   logic [CW-1:0]          period_shd;
   logic [CW-1:0]          period_safe;
   logic                   pend_q;
   logic                   take;

   assign commit      = at_end && (pend_q || unlock || auto_load);
   assign take        = !run_en || commit;
   assign period_safe = (period_shd == '0) ? CW'(1) : period_shd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_shd   <= '0;
         duty_act   <= '0;
         period_shd <= '0;
         period_act <= CW'(1);
         pend_q     <= 1'b0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (duty_wr && duty_sel == CHW'(i)) duty_shd[i] <= duty_data;
         end
         if (period_wr) period_shd <= period_data;
         if (take) begin
            duty_act   <= duty_shd;
            period_act <= period_safe;
         end
         if (take)        pend_q <= 1'b0;
         else if (unlock) pend_q <= 1'b1;
      end
   end

   a_r5_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !commit) |=> $stable(duty_act));
   a_r11_period_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !commit) |=> $stable(period_act));
   a_r7_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !pend_q);
   a_r8_auto_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && auto_load) |-> commit);
endmodule

// File: rtl/spb_compare.sv
module spb_compare #(
   parameter int NCH     = 4,
   parameter int CW      = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run_en,
   input  logic [NCH-1:0]         sync_mask,
   input  logic [CW-1:0]          cnt,
   input  logic [CW-1:0]          period_act,
   input  logic [NCH-1:0][CW-1:0] duty_act,
   output logic [NCH-1:0]         pwm_out
);
   logic [NCH-1:0] hit;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign hit[i] = run_en && sync_mask[i] && (cnt < duty_act[i]);
   end

   if (OUT_REG) begin : g_reg
      logic [NCH-1:0] out_q;
      always_ff @(posedge clk) begin
         if (!rst_n) out_q <= '0;
         else        out_q <= hit;
      end
      assign pwm_out = out_q;

      for (genvar i = 0; i < NCH; i++) begin : g_chk
         a_r9_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_act[i] == '0) |=> !pwm_out[i]);
         a_r10_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en && sync_mask[i] && duty_act[i] >= period_act) |=> pwm_out[i]);
         a_r12_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
            !sync_mask[i] |=> !pwm_out[i]);
      end
   end else begin : g_comb
      assign pwm_out = hit;
   end
endmodule

// File: rtl/sync_pwm_bank.sv
module sync_pwm_bank #(
   parameter int NCH     = 4,
   parameter int CW      = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_en,
   input  logic            centre_en,
   input  logic            auto_load,
   input  logic [NCH-1:0]  sync_mask,
   input  logic            period_wr,
   input  logic [CW-1:0]   period_data,
   input  logic            duty_wr,
   input  logic [CHW-1:0]  duty_sel,
   input  logic [CW-1:0]   duty_data,
   input  logic            unlock,
   output logic [NCH-1:0]  pwm_out
);
   if (NCH < 2) begin : g_bad_nch
      $error("sync_pwm_bank: NCH must be at least 2");
   end
   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("sync_pwm_bank: CW must be within 2..32");
   end

   logic [CW-1:0]          cnt;
   logic                   at_end;
   logic                   commit;
   logic [CW-1:0]          period_act;
   logic [NCH-1:0][CW-1:0] duty_act;

   spb_timebase #(.CW(CW)) u_time (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .centre_en(centre_en),
      .period_act(period_act), .cnt(cnt), .at_end(at_end)
   );

   spb_staging #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_stage (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .at_end(at_end),
      .auto_load(auto_load), .unlock(unlock),
      .period_wr(period_wr), .period_data(period_data),
      .duty_wr(duty_wr), .duty_sel(duty_sel), .duty_data(duty_data),
      .period_act(period_act), .duty_act(duty_act), .commit(commit)
   );

   spb_compare #(.NCH(NCH), .CW(CW), .OUT_REG(OUT_REG)) u_cmp (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_mask(sync_mask),
      .cnt(cnt), .period_act(period_act), .duty_act(duty_act),
      .pwm_out(pwm_out)
   );

   if (OUT_REG) begin : g_stop_chk
      a_r2_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
         !run_en |=> (pwm_out == '0));
   end
   a_r6_commit_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (run_en && at_end));
endmodule

// File: tb/sync_pwm_bank_tb.sv
`timescale 1ns/1ps
module sync_pwm_bank_tb;
   localparam int NCH = 4;
   localparam int CW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           run_en = 1'b0, centre_en = 1'b0, auto_load = 1'b0;
   logic [NCH-1:0] sync_mask = '1;
   logic           period_wr = 1'b0, duty_wr = 1'b0, unlock = 1'b0;
   logic [CW-1:0]  period_data = '0, duty_data = '0;
   logic [1:0]     duty_sel = '0;
   logic [NCH-1:0] pwm_out;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sync_pwm_bank #(.NCH(NCH), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .centre_en(centre_en),
      .auto_load(auto_load), .sync_mask(sync_mask),
      .period_wr(period_wr), .period_data(period_data),
      .duty_wr(duty_wr), .duty_sel(duty_sel), .duty_data(duty_data),
      .unlock(unlock), .pwm_out(pwm_out)
   );

   // Behavioural reference model
   int m_cnt, m_pact, m_pshd, m_pend;
   int m_dact[NCH];
   int m_dshd[NCH];
   bit m_up, m_end, m_ld;
   logic [NCH-1:0] m_out, m_next;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_up = 1; m_pact = 1; m_pshd = 0; m_pend = 0; m_out = '0;
         for (int i = 0; i < NCH; i++) begin m_dact[i] = 0; m_dshd[i] = 0; end
      end else begin
         for (int i = 0; i < NCH; i++)
            m_next[i] = run_en && sync_mask[i] && (m_cnt < m_dact[i]);
         if (centre_en) m_end = run_en && !m_up && (m_cnt == 0);
         else           m_end = run_en && (m_cnt >= m_pact - 1);
         m_ld = m_end && (m_pend != 0 || unlock || auto_load);
         if (!run_en) begin
            m_cnt = 0; m_up = 1;
         end else if (centre_en) begin
            if (m_up) begin
               if (m_cnt >= m_pact - 1) m_up = 0; else m_cnt++;
            end else begin
               if (m_cnt == 0) m_up = 1; else m_cnt--;
            end
         end else begin
            m_cnt = m_end ? 0 : m_cnt + 1;
         end
         if (!run_en || m_ld) begin
            m_pact = (m_pshd == 0) ? 1 : m_pshd;
            for (int i = 0; i < NCH; i++) m_dact[i] = m_dshd[i];
            m_pend = 0;
         end else if (unlock) begin
            m_pend = 1;
         end
         if (period_wr) m_pshd = int'(period_data);
         if (duty_wr)   m_dshd[duty_sel] = int'(duty_data);
         m_out = m_next;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (pwm_out !== m_out) begin
            failures++;
            $display("FAIL R3 R4 R6 model cycle compare: actual=%b expected=%b at %0t",
                     pwm_out, m_out, $time);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_duty(input int ch, input int v);
      @(negedge clk); duty_wr = 1'b1; duty_sel = 2'(ch); duty_data = CW'(v);
      @(negedge clk); duty_wr = 1'b0;
   endtask

   task automatic wr_period(input int v);
      @(negedge clk); period_wr = 1'b1; period_data = CW'(v);
      @(negedge clk); period_wr = 1'b0;
   endtask

   task automatic pulse_unlock();
      @(negedge clk); unlock = 1'b1;
      @(negedge clk); unlock = 1'b0;
   endtask

   task automatic measure(input int ch, input int n, output int hi);
      hi = 0;
      repeat (n) begin @(negedge clk); hi += int'(pwm_out[ch]); end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int hi, diff;
      idle(3);
      chk("R2 output low in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      idle(2);
      chk("R2 output low after reset", int'(pwm_out), 0);

      // Left-aligned, P=10, staged while stopped
      wr_period(10);
      wr_duty(0, 5); wr_duty(1, 0); wr_duty(2, 10); wr_duty(3, 3);
      idle(2);
      chk("R2 stopped stays low", int'(pwm_out), 0);
      run_en = 1'b1;
      idle(30);
      measure(0, 10, hi); chk("R3 duty 5 of 10", hi, 5);
      measure(1, 10, hi); chk("R9 duty 0 low", hi, 0);
      measure(2, 10, hi); chk("R10 duty equal period high", hi, 10);
      measure(3, 10, hi); chk("R3 duty 3 of 10", hi, 3);

      // Staged write without unlock
      wr_duty(0, 8);
      idle(30);
      measure(0, 10, hi); chk("R5 staged duty not applied", hi, 5);

      pulse_unlock();
      idle(20);
      measure(0, 10, hi); chk("R6 unlock commits duty", hi, 8);
      measure(3, 10, hi); chk("R6 other channel unchanged", hi, 3);

      // Double strobe then a later write without unlock
      wr_duty(3, 7);
      pulse_unlock(); pulse_unlock();
      idle(25);
      wr_duty(3, 1);
      idle(30);
      measure(3, 10, hi); chk("R7 pending cleared after commit", hi, 7);

      // Period shadowing
      wr_period(20);
      idle(30);
      measure(2, 20, hi); chk("R11 staged period not applied", hi, 20);
      pulse_unlock();
      idle(45);
      measure(2, 20, hi); chk("R11 new period committed", hi, 10);
      measure(0, 20, hi); chk("R11 duty 8 of 20", hi, 8);
      measure(3, 20, hi); chk("R6 staged duty committed with period", hi, 1);

      // Automatic commit
      auto_load = 1'b1;
      wr_duty(1, 4);
      idle(45);
      measure(1, 20, hi); chk("R8 auto commit", hi, 4);
      wr_duty(1, 17);
      idle(45);
      measure(1, 20, hi); chk("R8 auto commit second period", hi, 17);

      // Mask
      sync_mask = 4'b1110;
      idle(3);
      measure(0, 20, hi); chk("R12 masked channel low", hi, 0);
      sync_mask = 4'b1111;

      // Centre-aligned, P=10
      run_en = 1'b0;
      idle(2);
      chk("R2 stop forces low", int'(pwm_out), 0);
      centre_en = 1'b1;
      wr_period(10);
      wr_duty(0, 5); wr_duty(1, 4);
      idle(2);
      run_en = 1'b1;
      idle(60);
      measure(0, 20, hi); chk("R4 centre duty half gives 50%", hi, 10);
      measure(1, 20, hi); chk("R4 centre duty 4 of 10", hi, 8);
      measure(2, 20, hi); chk("R10 centre full high", hi, 20);

      // Shared counter: equal duty channels identical
      wr_duty(1, 5);
      idle(45);
      diff = 0;
      repeat (40) begin @(negedge clk); diff += int'(pwm_out[0] != pwm_out[1]); end
      chk("R1 equal duty channels aligned", diff, 0);

      // Period zero treated as one
      run_en = 1'b0; centre_en = 1'b0;
      wr_period(0); wr_duty(0, 1); wr_duty(1, 0);
      run_en = 1'b1;
      idle(5);
      measure(0, 6, hi); chk("R11 period zero as one, duty 1 high", hi, 6);
      measure(1, 6, hi); chk("R9 duty 0 with period one", hi, 0);

      run_en = 1'b0;
      idle(3);
      chk("R2 final stop low", int'(pwm_out), 0);
      finish_run();
   end
endmodule